// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Responder

This block is the network layer of a slave on a single-wire, open-drain, bit-serial bus. It carries a fixed 64-bit identity. A separate time-slot layer turns the line waveform into events and passes them on. Those events are a reset strobe, a strobe for each received bit together with its value, and a request for each read slot. The block answers every read slot with the level to place on the line: 0 pulls the line low and 1 releases it.

After each reset the block collects one 8-bit ROM-level command, least significant bit first. It then runs the matching sequence:

- **Identity readout:** sends all 64 identity bits.
- **Addressed selection:** compares 64 bits from the master with its own identity.
- **Direct selection:** selects the slave without any identity transfer.
- **Bitwise search arbitration:** for each bit, sends the bit, then its complement, then follows the master's chosen bit.
- **Alarm-gated search:** the same search, run only when the `alarm_flag` input is set.

When a sequence completes, the block raises a one-cycle strobe and holds a selected level. A downstream memory-command layer is allowed to act only while that level is high. An unrecognised command, or a failed comparison, parks the block until the next reset.

Top module: `owid_rom_responder`

## Requirements
- R1: The identity is ordered from least significant bit upward. Bits 7:0 hold the family code (parameter, default 10h). Bits 55:8 hold the 48-bit serial number. Bits 63:56 hold a CRC computed over bits 55:0: polynomial x^8+x^5+x^4+1, register initialised to zero, data fed in from bit 0 upward (reflected form, feedback constant 8Ch).
- R2: After reset the first eight `rx_valid` strobes form the command byte, first bit received = bit 0. Read slots during command reception return 1.
- R3: Command 33h returns the identity on the next 64 read slots, bit 0 first, and then selects the slave.
- R4: Command 55h compares the next 64 received bits with the identity, bit 0 first. If all of them match, the slave is selected. At the first mismatch the block goes idle until reset.
- R5: Command F0h runs, for each bit position from bit 0 upward, three steps. A read slot returns the identity bit. A second read slot returns its complement. A received bit is then compared with the identity bit: a match moves on to the next position, and a mismatch makes the block idle. Completing bit 63 selects the slave.
- R6: Command ECh behaves as F0h when `alarm_flag` is 1 on the cycle the eighth command bit arrives. Otherwise the block goes idle.
- R7: Command CCh selects the slave on the cycle after its eighth bit arrives, with no identity transfer.
- R8: Any other command byte makes the block ignore all received bits and read slots (read slots return 1) until the next reset.
- R9: `bus_reset` at any time returns the block to command reception on the next cycle, with `selected` low and `tx_bit` at 1.
- R10: `sel_stb` is high for exactly one cycle, the first cycle `selected` is high. `selected` then stays high until a bus reset.
- R11: `tx_bit` is 1 whenever the block is not sending an identity bit or a search bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle strobe: reset pulse detected on the line |
| rx_valid | input | 1 | One-cycle strobe: a bit written by the master was received |
| rx_bit | input | 1 | Value of the received bit |
| rd_req | input | 1 | One-cycle strobe: a read slot is consuming `tx_bit` |
| alarm_flag | input | 1 | Alarm condition from the measurement layer |
| tx_bit | output | 1 | Level for the current or next read slot (0 pulls low) |
| selected | output | 1 | Slave is addressed; memory commands are allowed |
| sel_stb | output | 1 | One-cycle strobe when selection completes |

## Verification
The hardest situations to reach from the ports are the search drop-out and match failure at bit 63. They need an exact, long stream of slots in which every earlier step agrees with the stored identity. The bench computes the identity and its CRC itself. It then drives full search passes in which the master follows the identity, and other passes in which it writes the opposite bit at a chosen position, including the last one. A behavioural model predicts `tx_bit`, `selected` and `sel_stb` on every clock, so read slots interleaved into command reception and resets issued mid-sequence are also compared cycle by cycle.

// File: rtl/owid_pkg.sv
package owid_pkg;

    localparam int ID_W     = 64;
    localparam int FAM_W    = 8;
    localparam int SER_W    = 48;
    localparam int CRC_W    = 8;
    localparam int BODY_W   = FAM_W + SER_W;
    localparam int CMD_W    = 8;
    localparam int IDX_W    = $clog2(ID_W);

    localparam logic [CMD_W-1:0] CMD_READ_ID  = 8'h33;
    localparam logic [CMD_W-1:0] CMD_MATCH_ID = 8'h55;
    localparam logic [CMD_W-1:0] CMD_SEARCH   = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_ALM_SRCH = 8'hEC;
    localparam logic [CMD_W-1:0] CMD_DIRECT   = 8'hCC;

    localparam logic [CRC_W-1:0] CRC_FEEDBACK = 8'h8C;

    typedef enum logic [2:0] {
        NS_CMD,
        NS_READ,
        NS_MATCH,
        NS_SEARCH,
        NS_SEL,
        NS_IDLE
    } net_state_e;

    typedef enum logic [1:0] {
        SP_TRUE,
        SP_COMP,
        SP_WRITE
    } srch_phase_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        logic [CRC_W-1:0] n;
        fb = c[0] ^ b;
        n  = c >> 1;
        if (fb) n = n ^ CRC_FEEDBACK;
        return n;
    endfunction

endpackage

// File: rtl/owid_identity.sv
module owid_identity
    import owid_pkg::*;
#(
    parameter logic [FAM_W-1:0] FAMILY_CODE   = 8'h10,
    parameter logic [SER_W-1:0] SERIAL_NUMBER = 48'h0008_3C5A_91E7
) (
    input  logic [IDX_W-1:0] idx,
    output logic             id_bit
);

    localparam logic [BODY_W-1:0] BODY = {SERIAL_NUMBER, FAMILY_CODE};

    logic [CRC_W-1:0] chain [0:BODY_W];
    logic [ID_W-1:0]  ident;

    assign chain[0] = '0;

    generate
        for (genvar i = 0; i < BODY_W; i++) begin : g_crc
            assign chain[i+1] = crc_step(chain[i], BODY[i]);
        end
    endgenerate

    assign ident  = {chain[BODY_W], BODY};
    assign id_bit = ident[idx];

endmodule

// File: rtl/owid_cmd_rx.sv
module owid_cmd_rx
    import owid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             rx_valid,
    input  logic             rx_bit,
    output logic             done,
    output logic [CMD_W-1:0] cmd
);

    localparam int CNT_W = $clog2(CMD_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

    typedef struct packed {
        logic [CMD_W-1:0] sr;
        logic [CNT_W-1:0] cnt;
    } rx_regs_t;

    rx_regs_t r_q, r_d;
    logic     take;

    assign take = enable && rx_valid && !clear;

    always_comb begin
        r_d  = r_q;
        done = 1'b0;
        if (clear) begin
            r_d.sr  = '0;
            r_d.cnt = '0;
        end else if (take) begin
            r_d.sr = {rx_bit, r_q.sr[CMD_W-1:1]};
            if (r_q.cnt == CNT_LAST) begin
                r_d.cnt = '0;
                done    = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    assign cmd = {rx_bit, r_q.sr[CMD_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/owid_net_fsm.sv
module owid_net_fsm
    import owid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic             rd_req,
    input  logic             alarm_flag,
    input  logic             cmd_done,
    input  logic [CMD_W-1:0] cmd,
    input  logic             id_bit,
    output logic [IDX_W-1:0] idx,
    output logic             cmd_en,
    output logic             tx_bit,
    output logic             selected,
    output logic             sel_stb
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

    typedef struct packed {
        net_state_e       st;
        srch_phase_e      ph;
        logic [IDX_W-1:0] idx;
        logic             stb;
    } fsm_regs_t;

    fsm_regs_t f_q, f_d;

    always_comb begin
        f_d     = f_q;
        f_d.stb = 1'b0;
        if (bus_reset) begin
            f_d.st  = NS_CMD;
            f_d.ph  = SP_TRUE;
            f_d.idx = '0;
        end else begin
            unique case (f_q.st)
                NS_CMD: begin
                    if (cmd_done) begin
                        f_d.idx = '0;
                        f_d.ph  = SP_TRUE;
                        unique case (cmd)
                            CMD_READ_ID:  f_d.st = NS_READ;
                            CMD_MATCH_ID: f_d.st = NS_MATCH;
                            CMD_SEARCH:   f_d.st = NS_SEARCH;
                            CMD_ALM_SRCH: f_d.st = alarm_flag ? NS_SEARCH : NS_IDLE;
                            CMD_DIRECT: begin
                                f_d.st  = NS_SEL;
                                f_d.stb = 1'b1;
                            end
                            default:      f_d.st = NS_IDLE;
                        endcase
                    end
                end
                NS_READ: begin
                    if (rd_req) begin
                        if (f_q.idx == IDX_LAST) begin
                            f_d.st  = NS_SEL;
                            f_d.stb = 1'b1;
                        end else begin
                            f_d.idx = f_q.idx + 1'b1;
                        end
                    end
                end
                NS_MATCH: begin
                    if (rx_valid) begin
                        if (rx_bit != id_bit) begin
                            f_d.st = NS_IDLE;
                        end else if (f_q.idx == IDX_LAST) begin
                            f_d.st  = NS_SEL;
                            f_d.stb = 1'b1;
                        end else begin
                            f_d.idx = f_q.idx + 1'b1;
                        end
                    end
                end
                NS_SEARCH: begin
                    unique case (f_q.ph)
                        SP_TRUE: if (rd_req) f_d.ph = SP_COMP;
                        SP_COMP: if (rd_req) f_d.ph = SP_WRITE;
                        SP_WRITE: begin
                            if (rx_valid) begin
                                f_d.ph = SP_TRUE;
                                if (rx_bit != id_bit) begin
                                    f_d.st = NS_IDLE;
                                end else if (f_q.idx == IDX_LAST) begin
                                    f_d.st  = NS_SEL;
                                    f_d.stb = 1'b1;
                                end else begin
                                    f_d.idx = f_q.idx + 1'b1;
                                end
                            end
                        end
                        default: f_d.ph = SP_TRUE;
                    endcase
                end
                NS_SEL:  f_d.st = NS_SEL;
                NS_IDLE: f_d.st = NS_IDLE;
                default: f_d.st = NS_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_bit = 1'b1;
        if (f_q.st == NS_READ) begin
            tx_bit = id_bit;
        end else if (f_q.st == NS_SEARCH) begin
            if (f_q.ph == SP_TRUE)      tx_bit = id_bit;
            else if (f_q.ph == SP_COMP) tx_bit = ~id_bit;
        end
    end

    assign idx      = f_q.idx;
    assign cmd_en   = (f_q.st == NS_CMD);
    assign selected = (f_q.st == NS_SEL);
    assign sel_stb  = f_q.stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st  <= NS_CMD;
            f_q.ph  <= SP_TRUE;
            f_q.idx <= '0;
            f_q.stb <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

endmodule

// File: rtl/owid_rom_responder.sv
module owid_rom_responder
    import owid_pkg::*;
#(
    parameter logic [FAM_W-1:0] FAMILY_CODE   = 8'h10,
    parameter logic [SER_W-1:0] SERIAL_NUMBER = 48'h0008_3C5A_91E7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic rd_req,
    input  logic alarm_flag,
    output logic tx_bit,
    output logic selected,
    output logic sel_stb
);

    logic [IDX_W-1:0] idx;
    logic             id_bit;
    logic             cmd_en;
    logic             cmd_done;
    logic [CMD_W-1:0] cmd;

    owid_identity #(
        .FAMILY_CODE  (FAMILY_CODE),
        .SERIAL_NUMBER(SERIAL_NUMBER)
    ) i_identity (
        .idx   (idx),
        .id_bit(id_bit)
    );

    owid_cmd_rx i_cmd_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (bus_reset),
        .enable  (cmd_en),
        .rx_valid(rx_valid),
        .rx_bit  (rx_bit),
        .done    (cmd_done),
        .cmd     (cmd)
    );

    owid_net_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .rd_req    (rd_req),
        .alarm_flag(alarm_flag),
        .cmd_done  (cmd_done),
        .cmd       (cmd),
        .id_bit    (id_bit),
        .idx       (idx),
        .cmd_en    (cmd_en),
        .tx_bit    (tx_bit),
        .selected  (selected),
        .sel_stb   (sel_stb)
    );

endmodule

// File: rtl/owid_responder_checker.sv
module owid_responder_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_reset,
    input logic tx_bit,
    input logic selected,
    input logic sel_stb
);

    AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stb |=> !sel_stb); // R10

    AST_STB_WITH_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stb |-> selected); // R10

    AST_SELECTED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !bus_reset) |=> (selected && !sel_stb)); // R10

    AST_RESET_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!selected && !sel_stb)); // R9

    AST_RESET_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> tx_bit); // R9

    AST_SELECTED_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        selected |-> tx_bit); // R11

endmodule

bind owid_rom_responder owid_responder_checker i_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_reset(bus_reset),
    .tx_bit   (tx_bit),
    .selected (selected),
    .sel_stb  (sel_stb)
);

// File: tb/test_owid_rom_responder.sv
module test_owid_rom_responder;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0]  FAM = 8'h10;
    localparam logic [47:0] SER = 48'h0008_3C5A_91E7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, rd_req = 1'b0, alarm_flag = 1'b0;
    logic tx_bit, selected, sel_stb;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R9";
    logic [63:0] ref_id;

    // behavioural reference state
    int m_st = 0;      // 0 cmd, 1 read, 2 match, 3 search, 4 selected, 5 idle
    int m_ph = 0;      // 0 true, 1 complement, 2 write
    int m_idx = 0;
    int m_cnt = 0;
    int m_byte = 0;
    bit m_stb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    owid_rom_responder i_owid_rom_responder (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .rd_req(rd_req), .alarm_flag(alarm_flag),
        .tx_bit(tx_bit), .selected(selected), .sel_stb(sel_stb)
    );

    function automatic logic [63:0] make_id();
        logic [7:0] c = 8'h00;
        logic [55:0] body = {SER, FAM};
        for (int i = 0; i < 56; i++) begin
            logic fb = c[0] ^ body[i];
            c = {1'b0, c[7:1]};
            if (fb) c = c ^ 8'h8C;
        end
        return {c, body};
    endfunction

    function automatic bit m_tx();
        if (m_st == 1) return ref_id[m_idx];
        if (m_st == 3 && m_ph == 0) return ref_id[m_idx];
        if (m_st == 3 && m_ph == 1) return ~ref_id[m_idx];
        return 1'b1;
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit rst, input bit rxv, input bit rxb, input bit rd);
        m_stb = 0;
        if (rst) begin
            m_st = 0; m_ph = 0; m_idx = 0; m_cnt = 0; m_byte = 0;
            return;
        end
        case (m_st)
            0: if (rxv) begin
                m_byte = (m_byte >> 1) | (int'(rxb) << 7);
                m_cnt++;
                if (m_cnt == 8) begin
                    m_cnt = 0; m_idx = 0; m_ph = 0;
                    if (m_byte == 'h33) m_st = 1;
                    else if (m_byte == 'h55) m_st = 2;
                    else if (m_byte == 'hF0) m_st = 3;
                    else if (m_byte == 'hEC) m_st = alarm_flag ? 3 : 5;
                    else if (m_byte == 'hCC) begin m_st = 4; m_stb = 1; end
                    else m_st = 5;
                end
            end
            1: if (rd) begin
                if (m_idx == 63) begin m_st = 4; m_stb = 1; end else m_idx++;
            end
            2: if (rxv) begin
                if (rxb != ref_id[m_idx]) m_st = 5;
                else if (m_idx == 63) begin m_st = 4; m_stb = 1; end
                else m_idx++;
            end
            3: begin
                if (m_ph == 0 && rd) m_ph = 1;
                else if (m_ph == 1 && rd) m_ph = 2;
                else if (m_ph == 2 && rxv) begin
                    m_ph = 0;
                    if (rxb != ref_id[m_idx]) m_st = 5;
                    else if (m_idx == 63) begin m_st = 4; m_stb = 1; end
                    else m_idx++;
                end
            end
            default: ;
        endcase
    endtask

    // drive one cycle of inputs, advance the model, compare at the next falling edge
    task automatic cyc(input bit rst, input bit rxv, input bit rxb, input bit rd);
        bus_reset = rst; rx_valid = rxv; rx_bit = rxb; rd_req = rd;
        model_step(rst, rxv, rxb, rd);
        @(negedge clk);
        bus_reset = 0; rx_valid = 0; rd_req = 0;
        check(cur_req, tx_bit, m_tx(), "tx_bit");
        check(cur_req, selected, (m_st == 4), "selected");
        check(cur_req, sel_stb, m_stb, "sel_stb");
    endtask

    task automatic wr_slot(input bit b);
        cyc(0, 1, b, 0);
        cyc(0, 0, 0, 0);
    endtask

    task automatic rd_slot(output bit b);
        b = tx_bit;
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr_slot(v[i]);
    endtask

    task automatic line_reset();
        cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
    endtask

    // one search pass; the master writes the identity bit except at flip_at
    task automatic search_pass(input int flip_at, input string req);
        bit t, c;
        for (int i = 0; i < 64; i++) begin
            rd_slot(t);
            rd_slot(c);
            if (m_st == 3 || i <= flip_at || flip_at < 0) begin
                check(req, t, ref_id[i], $sformatf("search true bit %0d", i));
                check(req, c, ~ref_id[i], $sformatf("search complement bit %0d", i));
            end else begin
                check(req, t, 1'b1, $sformatf("released after drop, slot %0d", i));
            end
            wr_slot((i == flip_at) ? ~ref_id[i] : ref_id[i]);
        end
    endtask

    initial begin
        int unsigned cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 200000) begin
                mismatched++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        bit b;
        logic [63:0] got;
        ref_id = make_id();
        // R1: the identity CRC appended over bits 55:0 leaves the CRC register at zero
        begin
            logic [7:0] c = 8'h00;
            for (int i = 0; i < 64; i++) begin
                logic fb = c[0] ^ ref_id[i];
                c = {1'b0, c[7:1]};
                if (fb) c = c ^ 8'h8C;
            end
            check("R1", (c == 8'h00), 1'b1, "crc residue zero");
            check("R1", (ref_id[7:0] == 8'h10), 1'b1, "family code in bits 7:0");
        end

        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R9";
        check("R9", tx_bit, 1'b1, "reset tx_bit");
        check("R9", selected, 1'b0, "reset selected");
        check("R10", sel_stb, 1'b0, "reset sel_stb");

        // R3: identity readout with a read slot interleaved in the command (R2)
        cur_req = "R2";
        line_reset();
        for (int i = 0; i < 4; i++) wr_slot(1'(8'h33 >> i));
        rd_slot(b);
        check("R2", b, 1'b1, "read slot during command");
        for (int i = 4; i < 8; i++) wr_slot(1'(8'h33 >> i));
        cur_req = "R3";
        for (int i = 0; i < 64; i++) begin rd_slot(b); got[i] = b; end
        check("R3", (got == ref_id), 1'b1, "identity read back");
        check("R10", selected, 1'b1, "selected after readout");
        wr_slot(1'b0);
        check("R10", selected, 1'b1, "selected holds");

        // R7: direct selection
        cur_req = "R7";
        line_reset();
        send_byte(8'hCC);
        check("R7", selected, 1'b1, "direct select");

        // R4: addressed match, full
        cur_req = "R4";
        line_reset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) wr_slot(ref_id[i]);
        check("R4", selected, 1'b1, "full match selects");
        // R4: mismatch at bit 37 and at bit 63
        line_reset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) wr_slot((i == 37) ? ~ref_id[i] : ref_id[i]);
        check("R4", selected, 1'b0, "mismatch 37 no select");
        rd_slot(b);
        check("R4", b, 1'b1, "idle after mismatch releases");
        line_reset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) wr_slot((i == 63) ? ~ref_id[i] : ref_id[i]);
        check("R4", selected, 1'b0, "mismatch 63 no select");

        // R5: search following the identity, then drop at bit 10 and bit 63
        cur_req = "R5";
        line_reset();
        send_byte(8'hF0);
        search_pass(-1, "R5");
        check("R5", selected, 1'b1, "search completes");
        line_reset();
        send_byte(8'hF0);
        search_pass(10, "R5");
        check("R5", selected, 1'b0, "search drop at 10");
        line_reset();
        send_byte(8'hF0);
        search_pass(63, "R5");
        check("R5", selected, 1'b0, "search drop at 63");

        // R6: alarm-gated search
        cur_req = "R6";
        alarm_flag = 1'b1;
        line_reset();
        send_byte(8'hEC);
        search_pass(-1, "R6");
        check("R6", selected, 1'b1, "alarm search with alarm");
        alarm_flag = 1'b0;
        line_reset();
        send_byte(8'hEC);
        rd_slot(b);
        check("R6", b, 1'b1, "alarm search without alarm releases");
        rd_slot(b);
        wr_slot(1'b1);
        check("R6", selected, 1'b0, "alarm search without alarm idle");

        // R8: unknown command
        cur_req = "R8";
        line_reset();
        send_byte(8'hA5);
        for (int i = 0; i < 6; i++) begin
            rd_slot(b);
            check("R8", b, 1'b1, "unknown command read slot");
        end
        send_byte(8'hCC);
        check("R8", selected, 1'b0, "unknown command ignores later bytes");

        // R9: reset in the middle of readout and search, then a fresh command
        cur_req = "R9";
        line_reset();
        send_byte(8'h33);
        for (int i = 0; i < 20; i++) rd_slot(b);
        line_reset();
        check("R9", tx_bit, 1'b1, "reset mid readout");
        send_byte(8'hCC);
        check("R9", selected, 1'b1, "command after reset");
        line_reset();
        check("R9", selected, 1'b0, "reset clears selected");
        send_byte(8'hF0);
        rd_slot(b);
        line_reset();
        cur_req = "R11";
        for (int i = 0; i < 4; i++) wr_slot(1'b0);
        rd_slot(b);
        check("R11", b, 1'b1, "released while receiving command");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule